// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block runs single-word read and write transactions on a serial configuration EEPROM with a three-wire select, clock and data interface. The host issues a command word that holds a 2-bit opcode and an 8-bit word address. It polls a busy bit in a self-status word until the serial transfer is over, and then collects a read result from a separate data-word output. For a write, the block presents the bit sequence and deselects the device for one bit cell. It then reselects the device and stays busy until the device reports that programming has finished.

Out of reset, and again after a soft reset, the sequencer reads a parameterised run of configuration words before it accepts any host command. It hands each word out on a configuration port. When the last word has arrived it raises an initialisation-done flag. From the same load it derives a presence flag and a contents-valid flag.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `self_stat` reads 16'h0100 (busy set, every other flag clear) and `ee_cs`, `ee_sk` and `ee_di` are low.
- R2: After reset the block reads LOAD_WORDS words, starting at address LOAD_BASE and counting upward. Each word is presented for one cycle on `cfg_we`/`cfg_addr`/`cfg_data`. Together with the last word, self-status bit 7 (init done) rises and busy falls.
- R3: Self-status bit 9 (present) is set after the load exactly when the first loaded word is not 16'hFFFF.
- R4: Self-status bit 10 (contents OK) is set after the load exactly when the device is present and the 16-bit wrapping sum of all loaded words is zero.
- R5: A command with `cmd_word[9:8]` = 2'b10 is a read of the address in `cmd_word[7:0]`. It shifts out a 1 start bit, the opcode and the address, each MSB first, then clocks in 16 bits MSB first. The word appears on `rd_data` in the cycle busy falls.
- R6: A command with `cmd_word[9:8]` = 2'b01 is a write. It shifts out the start bit, the opcode, the address and then `cmd_wdata`, each MSB first. It then drops `ee_cs` for one bit cell, raises it again and keeps busy set until `ee_do` is high.
- R7: Self-status bit 8 (busy) is high from the cycle after a command is accepted until the transfer completes, and `ee_cs` is high in that first cycle.
- R8: A command presented while busy is set is ignored. It causes no serial traffic and leaves no trace in `rd_data` or in the device.
- R9: Commands with opcode 2'b00 or 2'b11 are ignored: busy stays low and `ee_cs` stays low.
- R10: Each bit cell lasts 2*HALF_DIV clocks. `ee_sk` is low for the first HALF_DIV clocks and high for the last HALF_DIV. `ee_di` does not change while `ee_sk` is high, and `ee_do` is sampled on the last clock of the cell. `ee_cs` is low whenever busy is clear.
- R11: A pulse on `soft_rst_req` stands for a host write of self-control bit 6. It clears init done, present and OK in the next cycle, sets busy and reruns the automatic load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 10 | [9:8] opcode, [7:0] word address |
| cmd_wdata | input | 16 | Data word for a write command |
| soft_rst_req | input | 1 | Soft reset strobe (self-control bit 6 written as 1) |
| rd_data | output | 16 | Data-word register holding the last read result |
| self_stat | output | 16 | Bit 7 init done, 8 busy, 9 present, 10 contents OK |
| cfg_we | output | 1 | One-cycle strobe for each automatically loaded word |
| cfg_addr | output | 8 | Address of the loaded word |
| cfg_data | output | 16 | Loaded word |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The assertions assume that the soft reset strobe is only pulsed while no host transfer or write programming is in progress. They also assume that the device answers a write by holding `ee_do` low until programming is done and then releasing it high. The bench's responder model follows that contract. It drives read data on the rising serial clock edge, keeps `ee_do` high when idle, and can be switched into an absent mode that reads as all ones. Host commands are applied only on falling system clock edges, and soft resets are issued only after busy has cleared, so the stimulus stays inside those assumptions.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  // start bit + opcode + 8-bit address + 16 data cells
  localparam int FRAME_W = 1 + 2 + 8 + 16;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SHIFT,
    S_DESEL,
    S_POLL
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [1:0]  op,
    input logic [7:0]  addr,
    input logic [15:0] wd
  );
    return {1'b1, op, addr, wd};
  endfunction

  function automatic logic [15:0] sum16(input logic [15:0] acc, input logic [15:0] w);
    return acc + w;
  endfunction

  function automatic logic word_blank(input logic [15:0] w);
    return (w == 16'hFFFF);
  endfunction

endpackage

// File: rtl/ee_bit_timer.sv
module ee_bit_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sk_phase,
  output logic cell_end
);
  localparam int CELL = 2 * HALF_DIV;
  localparam int CW   = (CELL > 2) ? $clog2(CELL) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cell_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sk_phase = run && (cnt_q >= CW'(HALF_DIV));
  assign cell_end = run && (cnt_q == CW'(CELL - 1));
endmodule

// File: rtl/ee_shifter.sv
module ee_shifter #(
  parameter int FRAME_W = 27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               step,
  input  logic               sdi,
  output logic               sdo,
  output logic [15:0]        rx_now
);
  logic [FRAME_W-1:0] tx_q;
  logic [14:0]        rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= frame;
      rx_q <= '0;
    end else if (step) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      rx_q <= rx_now[14:0];
    end
  end

  assign sdo    = tx_q[FRAME_W-1];
  assign rx_now = {rx_q, sdi};
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int LOAD_WORDS = 4,
  parameter int LOAD_BASE  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [9:0]  cmd_word,
  input  logic [15:0] cmd_wdata,
  input  logic        soft_rst_req,
  output logic [15:0] rd_data,
  output logic [15:0] self_stat,
  output logic        cfg_we,
  output logic [7:0]  cfg_addr,
  output logic [15:0] cfg_data,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int LD_W = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1;
  localparam int BC_W = $clog2(FRAME_W);

  seq_state_t       state_q;
  logic             load_pend_q, from_load_q;
  logic [LD_W-1:0]  ld_cnt_q;
  logic [BC_W-1:0]  bit_q;
  logic [1:0]       op_q;
  logic [7:0]       addr_q;
  logic [15:0]      sum_q;
  logic             init_done_q, present_q, ok_q;

  // named internal events
  logic        start_load, cmd_accept, go, frame_done, desel_done, poll_ready;
  logic        run, sk_phase, cell_end, sdo;
  logic [1:0]  go_op;
  logic [7:0]  go_addr;
  logic [15:0] rx_now, sum_next;
  logic        pres_next, last_word;

  assign start_load = (state_q == S_IDLE) && load_pend_q;
  assign cmd_accept = (state_q == S_IDLE) && !load_pend_q && cmd_we &&
                      ((cmd_word[9:8] == OP_RD) || (cmd_word[9:8] == OP_WR));
  assign go         = start_load || cmd_accept;
  assign go_op      = start_load ? OP_RD : cmd_word[9:8];
  assign go_addr    = start_load ? (8'(LOAD_BASE) + 8'(ld_cnt_q)) : cmd_word[7:0];
  assign frame_done = (state_q == S_SHIFT) && cell_end && (bit_q == BC_W'(FRAME_W - 1));
  assign desel_done = (state_q == S_DESEL) && cell_end;
  assign poll_ready = (state_q == S_POLL) && ee_do;
  assign run        = (state_q == S_SHIFT) || (state_q == S_DESEL);

  assign sum_next  = sum16(sum_q, rx_now);
  assign pres_next = (ld_cnt_q == '0) ? !word_blank(rx_now) : present_q;
  assign last_word = (ld_cnt_q == LD_W'(LOAD_WORDS - 1));

  ee_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .sk_phase(sk_phase), .cell_end(cell_end)
  );

  ee_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(go),
    .frame(build_frame(go_op, go_addr, start_load ? 16'h0000 : cmd_wdata)),
    .step((state_q == S_SHIFT) && cell_end), .sdi(ee_do),
    .sdo(sdo), .rx_now(rx_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;   load_pend_q <= 1'b1; from_load_q <= 1'b0;
      ld_cnt_q <= '0;      bit_q <= '0;         op_q <= OP_RD;
      addr_q <= '0;        sum_q <= '0;         rd_data <= '0;
      init_done_q <= 1'b0; present_q <= 1'b0;   ok_q <= 1'b0;
      cfg_we <= 1'b0;      cfg_addr <= '0;      cfg_data <= '0;
    end else if (soft_rst_req) begin
      state_q <= S_IDLE;   load_pend_q <= 1'b1; from_load_q <= 1'b0;
      ld_cnt_q <= '0;      bit_q <= '0;         op_q <= OP_RD;
      addr_q <= '0;        sum_q <= '0;
      init_done_q <= 1'b0; present_q <= 1'b0;   ok_q <= 1'b0;
      cfg_we <= 1'b0;
    end else begin
      cfg_we <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go) begin
          state_q     <= S_SHIFT;
          bit_q       <= '0;
          op_q        <= go_op;
          addr_q      <= go_addr;
          from_load_q <= start_load;
        end
        S_SHIFT: if (cell_end) begin
          bit_q <= bit_q + 1'b1;
          if (frame_done) begin
            if (op_q == OP_WR) begin
              state_q <= S_DESEL;
            end else begin
              state_q <= S_IDLE;
              if (from_load_q) begin
                cfg_we    <= 1'b1;
                cfg_addr  <= addr_q;
                cfg_data  <= rx_now;
                present_q <= pres_next;
                sum_q     <= sum_next;
                if (last_word) begin
                  load_pend_q <= 1'b0;
                  init_done_q <= 1'b1;
                  ok_q        <= pres_next && (sum_next == 16'h0000);
                end else begin
                  ld_cnt_q <= ld_cnt_q + 1'b1;
                end
              end else begin
                rd_data <= rx_now;
              end
            end
          end
        end
        S_DESEL: if (desel_done) state_q <= S_POLL;
        S_POLL:  if (poll_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ee_cs = (state_q == S_SHIFT) || (state_q == S_POLL);
  assign ee_sk = (state_q == S_SHIFT) && sk_phase;
  assign ee_di = (state_q == S_SHIFT) && sdo;

  always_comb begin
    self_stat     = 16'h0000;
    self_stat[7]  = init_done_q;
    self_stat[8]  = (state_q != S_IDLE) || load_pend_q;
    self_stat[9]  = present_q;
    self_stat[10] = ok_q;
  end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst_req,
  input logic busy,
  input logic init_done,
  input logic present,
  input logic ok,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  // R10
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_cs);

  // R10
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R10
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R2
  idle_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> init_done);

  // R2
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !soft_rst_req) |=> init_done);

  // R4
  ok_needs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> present);

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> (busy && !init_done && !present && !ok));
endmodule

bind eeprom_cmd_seq eeprom_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_req(soft_rst_req),
  .busy(self_stat[8]), .init_done(self_stat[7]),
  .present(self_stat[9]), .ok(self_stat[10]),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/eeprom_cmd_seq_tb.sv
`timescale 1ns/1ps
module eeprom_cmd_seq_tb;
  localparam int HALF = 2;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [9:0] cmd_word = '0;
  logic [15:0] cmd_wdata = '0;
  logic soft_rst_req = 1'b0;
  logic [15:0] rd_data, self_stat, cfg_data;
  logic cfg_we, ee_cs, ee_sk, ee_di, ee_do;
  logic [7:0] cfg_addr;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_cmd_seq #(.HALF_DIV(HALF), .LOAD_WORDS(4), .LOAD_BASE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cmd_wdata(cmd_wdata), .soft_rst_req(soft_rst_req), .rd_data(rd_data),
    .self_stat(self_stat), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input logic cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM responder ----------------
  logic [15:0] mem [256];
  logic        bk_we = 1'b0;
  logic [7:0]  bk_addr = '0;
  logic [15:0] bk_data = '0;
  logic        dev_absent = 1'b0;
  logic        do_r = 1'b1;
  logic        sk_prev = 1'b0;
  logic [10:0] hdr = '0, cap_hdr = '0;
  logic [15:0] wsh = '0;
  int k = 0, kn = 0, prog_cnt = 0, frames = 0, writes = 0;

  assign ee_do = dev_absent ? 1'b1 : do_r;

  always @(posedge clk) begin
    if (bk_we) mem[bk_addr] <= bk_data;
    if (!ee_cs) begin
      k <= 0;
      if (prog_cnt == 0) do_r <= 1'b1;
    end
    if (prog_cnt > 0) begin
      prog_cnt <= prog_cnt - 1;
      if (prog_cnt == 1) do_r <= 1'b1;
    end
    if (ee_cs && ee_sk && !sk_prev) begin
      kn = k + 1;
      k <= kn;
      if (kn <= 11) hdr <= {hdr[9:0], ee_di};
      if (kn == 11) begin
        cap_hdr <= {hdr[9:0], ee_di};
        frames <= frames + 1;
      end
      if (kn >= 12 && kn <= 27 && cap_hdr[9:8] == 2'b10)
        do_r <= mem[cap_hdr[7:0]][27-kn];
      if (kn >= 12 && kn <= 27 && cap_hdr[9:8] == 2'b01) begin
        wsh <= {wsh[14:0], ee_di};
        if (kn == 27) begin
          mem[cap_hdr[7:0]] <= {wsh[14:0], ee_di};
          writes <= writes + 1;
          do_r <= 1'b0;
          prog_cnt <= PROG;
        end
      end
    end
    sk_prev <= ee_sk;
  end

  // configuration port log and busy-during-programming monitor
  logic [7:0]  cfg_a [8];
  logic [15:0] cfg_d [8];
  int cfg_n = 0;
  logic drop_in_prog = 1'b0;
  always @(posedge clk) begin
    if (cfg_we && cfg_n < 8) begin
      cfg_a[cfg_n] <= cfg_addr;
      cfg_d[cfg_n] <= cfg_data;
      cfg_n <= cfg_n + 1;
    end
    if (rst_n && prog_cnt > 0 && !self_stat[8]) drop_in_prog <= 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_addr = a; bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (self_stat[8] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(!self_stat[8], tag, 32'(self_stat[8]), 32'd0);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = {op, a}; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic soft_reset;
    @(negedge clk);
    soft_rst_req = 1'b1;
    @(negedge clk);
    soft_rst_req = 1'b0;
  endtask

  function automatic logic [15:0] table_sum;
    logic [15:0] s = 16'h0;
    for (int i = 0; i < 4; i++) s = s + mem[i];
    return s;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(self_stat == 16'h0100, "R1 status after reset", 32'(self_stat), 32'h0100);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 serial pins idle", 32'({ee_cs, ee_sk, ee_di}), 32'd0);
  endtask

  task automatic t_autoload;
    wait_idle("R2 load completes");
    @(negedge clk);
    chk(self_stat[7], "R2 init done", 32'(self_stat[7]), 32'd1);
    chk(cfg_n == 4, "R2 word count", 32'(cfg_n), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk(cfg_a[i] == 8'(i), "R2 load address order", 32'(cfg_a[i]), 32'(i));
      chk(cfg_d[i] == mem[i], "R2 load data", 32'(cfg_d[i]), 32'(mem[i]));
    end
    chk(self_stat[9], "R3 present", 32'(self_stat[9]), 32'd1);
    chk(self_stat[10], "R4 contents ok", 32'(self_stat[10]), 32'd1);
  endtask

  task automatic t_read;
    int lo = 0, hi = 0, f0;
    f0 = frames;
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = {2'b10, 8'h40};
    @(negedge clk);
    cmd_we = 1'b0;
    chk(self_stat[8], "R7 busy after accept", 32'(self_stat[8]), 32'd1);
    chk(ee_cs, "R7 cs after accept", 32'(ee_cs), 32'd1);
    while (!ee_sk && lo < 50) begin lo++; @(negedge clk); end
    while (ee_sk && hi < 50) begin hi++; @(negedge clk); end
    chk(lo == HALF, "R10 sk low phase", 32'(lo), 32'(HALF));
    chk(hi == HALF, "R10 sk high phase", 32'(hi), 32'(HALF));
    wait_idle("R5 read completes");
    chk(rd_data == 16'hBEEF, "R5 read data", 32'(rd_data), 32'hBEEF);
    chk(cap_hdr == {1'b1, 2'b10, 8'h40}, "R5 header bits", 32'(cap_hdr), 32'({1'b1, 2'b10, 8'h40}));
    chk(frames == f0 + 1, "R5 one frame", 32'(frames), 32'(f0 + 1));
  endtask

  task automatic t_write;
    int w0;
    w0 = writes;
    issue(2'b01, 8'h41, 16'h1357);
    wait_idle("R6 write completes");
    chk(writes == w0 + 1, "R6 one write", 32'(writes), 32'(w0 + 1));
    chk(mem[8'h41] == 16'h1357, "R6 written word", 32'(mem[8'h41]), 32'h1357);
    chk(!drop_in_prog, "R6 busy held while programming", 32'(drop_in_prog), 32'd0);
    chk(cap_hdr == {1'b1, 2'b01, 8'h41}, "R6 header bits", 32'(cap_hdr), 32'({1'b1, 2'b01, 8'h41}));
    issue(2'b10, 8'h41, 16'h0);
    wait_idle("R6 readback completes");
    chk(rd_data == 16'h1357, "R6 readback", 32'(rd_data), 32'h1357);
  endtask

  task automatic t_ignore_busy;
    int f0, w0;
    f0 = frames; w0 = writes;
    issue(2'b10, 8'h40, 16'h0);
    issue(2'b01, 8'h40, 16'h0000);
    issue(2'b10, 8'h41, 16'h0);
    wait_idle("R8 first command completes");
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R8 extra frames", 32'(frames), 32'(f0 + 1));
    chk(writes == w0, "R8 no write", 32'(writes), 32'(w0));
    chk(rd_data == 16'hBEEF, "R8 result kept", 32'(rd_data), 32'hBEEF);
    chk(mem[8'h40] == 16'hBEEF, "R8 device untouched", 32'(mem[8'h40]), 32'hBEEF);
  endtask

  task automatic t_bad_op;
    int f0, bad = 0;
    f0 = frames;
    issue(2'b00, 8'h40, 16'h0);
    issue(2'b11, 8'h41, 16'h0);
    for (int i = 0; i < 30; i++) begin
      if (self_stat[8] || ee_cs) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 no activity", 32'(bad), 32'd0);
    chk(frames == f0, "R9 no frame", 32'(frames), 32'(f0));
  endtask

  task automatic t_soft_reset;
    logic [15:0] keep;
    dev_absent = 1'b1;
    cfg_n = 0;
    soft_reset();
    chk(self_stat == 16'h0100, "R11 flags cleared", 32'(self_stat), 32'h0100);
    wait_idle("R11 reload completes");
    @(negedge clk);
    chk(self_stat[7], "R11 init done again", 32'(self_stat[7]), 32'd1);
    chk(!self_stat[9], "R3 absent device", 32'(self_stat[9]), 32'd0);
    chk(!self_stat[10], "R4 absent not ok", 32'(self_stat[10]), 32'd0);
    dev_absent = 1'b0;
    keep = mem[3];
    poke(8'd3, keep + 16'd1);
    soft_reset();
    wait_idle("R4 reload bad sum");
    @(negedge clk);
    chk(table_sum() != 16'h0, "R4 table sum nonzero", 32'(table_sum()), 32'd1);
    chk(self_stat[9], "R3 present again", 32'(self_stat[9]), 32'd1);
    chk(!self_stat[10], "R4 bad sum", 32'(self_stat[10]), 32'd0);
    poke(8'd3, keep);
    soft_reset();
    wait_idle("R11 reload good sum");
    @(negedge clk);
    chk(self_stat[10:7] == 4'b1101, "R11 full recovery", 32'(self_stat[10:7]), 32'hD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", 100000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    poke(8'd0, 16'h1234);
    poke(8'd1, 16'h0001);
    poke(8'd2, 16'hA5A5);
    poke(8'd3, 16'h0000 - (16'h1234 + 16'h0001 + 16'hA5A5));
    poke(8'h40, 16'hBEEF);
    poke(8'h41, 16'h5A5A);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_autoload();
    t_read();
    t_write();
    t_ignore_busy();
    t_bad_op();
    t_soft_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule